// File: doc/BRIEF.md
# Split next-sequential-PC incrementer

This block produces the address of the next sequential instruction from the currently selected program counter and two length flags taken from instruction decode. One flag says the instruction carries a register-specifier byte. The other says it carries a 4-byte constant. Together the two flags give an instruction length of 1, 2, 5 or 6 bytes.

The addition is split so that most of it does not wait for the instruction bytes. The upper part of the PC (all bits above the low three) is incremented by one as soon as the PC is known. This runs alongside the instruction-memory read. When the flags arrive, a 3-bit adder adds the length to the low three PC bits and gives a 3-bit sum and a carry. The carry then selects either the unchanged upper part or the incremented upper part.

The core path is purely combinational. A registered copy of the result is also provided so the block can be timed and checked from a clocked harness.

Top module: `fetch_pc_inc`

## Requirements
- R1: For every PC value and flag pair, `next_pc` equals `pc` plus the instruction length, modulo 2^PC_W.
- R2: With `has_reg`=0 and `has_const`=0, the length is 1.
- R3: With `has_reg`=1 and `has_const`=0, the length is 2.
- R4: With `has_reg`=0 and `has_const`=1, the length is 5.
- R5: With `has_reg`=1 and `has_const`=1, the length is 6.
- R6: When the low three PC bits plus the length stay below 8, the upper bits `next_pc[PC_W-1:3]` equal `pc[PC_W-1:3]`.
- R7: When the low three PC bits plus the length reach 8 or more, the upper bits equal `pc[PC_W-1:3]` + 1, modulo 2^(PC_W-3).
- R8: At the top of the address space the result wraps. For example, `pc`=0xFFFFFFFF with length 1 gives 0x00000000, and `pc`=0xFFFFFFFE with length 6 gives 0x00000004.
- R9: While `rst_n` is low, `next_pc_q` is 0. After reset, `next_pc_q` holds the `next_pc` value present at the previous rising clock edge.
- R10: `next_pc[2:0]` equals (`pc[2:0]` + length) modulo 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered copy |
| rst_n | input | 1 | Active-low synchronous reset of the registered copy |
| pc | input | PC_W | Selected program counter |
| has_reg | input | 1 | Instruction carries a register-specifier byte |
| has_const | input | 1 | Instruction carries a 4-byte constant |
| next_pc | output | PC_W | Combinational next sequential PC |
| next_pc_q | output | PC_W | Registered copy of `next_pc` |

## Verification
Checked on every clock cycle by the assertions:
- the full-width sum;
- the low-bit sum;
- the choice between the held and the incremented upper part, decided by whether the low add carries;
- the one-cycle lag of the registered copy.

Only the bench's directed scenarios can show the exact wrap values at the top of the address space, each of the four specific lengths, and the cleared register during reset. Those scenarios include PCs just below a multiple of 8 and all-ones.

// File: rtl/fetch_pc_inc.sv
module fetch_pc_inc #(
  parameter int PC_W  = 32,
  parameter int LOW_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pc,
  input  logic            has_reg,
  input  logic            has_const,
  output logic [PC_W-1:0] next_pc,
  output logic [PC_W-1:0] next_pc_q
);
  localparam int UP_W = PC_W - LOW_W;

  logic [UP_W-1:0]  up_inc;
  logic [LOW_W-1:0] len;
  logic [LOW_W-1:0] low_sum;
  logic             carry;

  // upper increment depends on pc only, so it overlaps the memory read
  assign up_inc = pc[PC_W-1:LOW_W] + UP_W'(1);

  assign len = LOW_W'(1) + (has_reg ? LOW_W'(1) : '0) + (has_const ? LOW_W'(4) : '0);

  assign {carry, low_sum} = {1'b0, pc[LOW_W-1:0]} + {1'b0, len};

  assign next_pc = {carry ? up_inc : pc[PC_W-1:LOW_W], low_sum};

  always_ff @(posedge clk) begin
    if (!rst_n) next_pc_q <= '0;
    else        next_pc_q <= next_pc;
  end
endmodule

// File: rtl/fetch_pc_inc_chk.sv
module fetch_pc_inc_chk #(
  parameter int PC_W  = 32,
  parameter int LOW_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc,
  input logic            has_reg,
  input logic            has_const,
  input logic [PC_W-1:0] next_pc,
  input logic [PC_W-1:0] next_pc_q
);
  logic [PC_W-1:0]  span;
  logic [LOW_W:0]   low_tot;

  assign span    = PC_W'(1) + PC_W'(has_reg) + (has_const ? PC_W'(4) : '0);
  assign low_tot = {1'b0, pc[LOW_W-1:0]} + (LOW_W+1)'(span);

  p_full_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc == pc + span);

  p_low_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc[LOW_W-1:0] == low_tot[LOW_W-1:0]);

  p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !low_tot[LOW_W] |-> next_pc[PC_W-1:LOW_W] == pc[PC_W-1:LOW_W]);

  p_upper_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_tot[LOW_W] |-> next_pc[PC_W-1:LOW_W] == pc[PC_W-1:LOW_W] + (PC_W-LOW_W)'(1));

  p_reg_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> next_pc_q == $past(next_pc));
endmodule

bind fetch_pc_inc fetch_pc_inc_chk #(.PC_W(PC_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .has_reg(has_reg), .has_const(has_const),
  .next_pc(next_pc), .next_pc_q(next_pc_q)
);

// File: tb/fetch_pc_inc_test.sv
`timescale 1ns/1ps
module fetch_pc_inc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic        has_reg = 1'b0;
  logic        has_const = 1'b0;
  logic [31:0] next_pc, next_pc_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fetch_pc_inc uut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .has_reg(has_reg), .has_const(has_const),
    .next_pc(next_pc), .next_pc_q(next_pc_q)
  );

  function automatic logic [31:0] len_of(input logic r, input logic c);
    return 32'd1 + (r ? 32'd1 : 32'd0) + (c ? 32'd4 : 32'd0);
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] p, input logic r, input logic c);
    return p + len_of(r, c);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] p, input logic r, input logic c, input string req);
    logic [31:0] e;
    logic [3:0]  lo;
    @(negedge clk);
    pc = p; has_reg = r; has_const = c;
    #1;
    e  = exp_next(p, r, c);
    lo = {1'b0, p[2:0]} + len_of(r, c)[3:0];
    check(req, next_pc, e);
    check("R10", {29'd0, next_pc[2:0]}, {29'd0, lo[2:0]});
    if (lo[3]) check("R7", {3'd0, next_pc[31:3]}, {3'd0, p[31:3] + 29'd1});
    else       check("R6", {3'd0, next_pc[31:3]}, {3'd0, p[31:3]});
    @(posedge clk); #1;
    check("R9", next_pc_q, e);
  endtask

  function automatic string len_req(input logic r, input logic c);
    case ({r, c})
      2'b00: return "R2";
      2'b10: return "R3";
      2'b01: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    pc = 32'h0000_0007; has_reg = 1'b1; has_const = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R9 reset", next_pc_q, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    apply(32'h0000_1000, 1'b0, 1'b0, "R2");
    apply(32'h0000_1000, 1'b1, 1'b0, "R3");
    apply(32'h0000_1000, 1'b0, 1'b1, "R4");
    apply(32'h0000_1000, 1'b1, 1'b1, "R5");
    for (int lo = 0; lo < 8; lo++)
      for (int f = 0; f < 4; f++)
        apply(32'h1234_5670 | 32'(lo), f[1], f[0], len_req(f[1], f[0]));
    apply(32'h0000_0007, 1'b0, 1'b0, "R7");
    apply(32'h0000_0002, 1'b1, 1'b1, "R7");
    apply(32'h0000_0001, 1'b1, 1'b1, "R6");
    apply(32'hFFFF_FFFF, 1'b0, 1'b0, "R8");
    apply(32'hFFFF_FFFE, 1'b1, 1'b1, "R8");
    apply(32'hFFFF_FFF8, 1'b1, 1'b1, "R8");
    apply(32'h7FFF_FFFF, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] p;
      logic [1:0]  f;
      p = $urandom();
      f = 2'($urandom());
      if (i % 5 == 0) p[2:0] = 3'd7;
      apply(p, f[1], f[0], "R1");
    end
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule